// File: doc/BRIEF.md
# Processor Reset Supervisor with Activity Watchdog

The block is the digital core of a processor supervisor. It drives one reset output from three sources. The first is a synchronous supply-good flag that an external threshold comparator provides. The second is a watchdog input that the processor must keep toggling. The third is a free-running timebase tick that sets the pace of all timing.

Reset is asserted in three cases:
- at power-up;
- whenever the supply-good flag drops, for as long as it stays low;
- when the watchdog input shows no transition for a full timeout.

Every reset is stretched to a fixed pulse width, counted in ticks. The counting starts once the supply is good.

The watchdog input and its "floating" detect flag pass through a two-flop synchronizer. Either edge of the watchdog input restarts the timeout. While the flag reports the input as floating, the watchdog is disabled. After a watchdog reset pulse ends, a fresh full timeout begins. A stuck input therefore yields a periodic reset, with a period of timeout plus pulse width.

The timeout and the pulse width are parameters in ticks. A real system scales them with a 1 ms tick (1600 and 200). A parameter selects the output polarity.

Top module: `sup_core`

## Requirements
- R1: While rst_ni is low the reset output is asserted. After rst_ni rises it stays asserted as long as supply_ok_i is low.
- R2: A low supply_ok_i sampled at a clock edge asserts the reset output after that edge. It stays asserted for every cycle that supply_ok_i stays low.
- R3: A rising supply_ok_i moves the block into its pulse phase at the next clock edge. The tick at that edge is not counted. Counting ticks from the following edges, reset releases after the edge that carries the PULSE_TICKS-th tick. If supply_ok_i drops during the pulse, the count restarts from zero when it returns.
- R4: Once reset has released, suppose the synchronized watchdog input has no edge for TIMEOUT_TICKS ticks. Then reset asserts after the edge that carries the TIMEOUT_TICKS-th tick. The pulse that follows lasts PULSE_TICKS ticks, counted from the next edge.
- R5: A rising or a falling edge of wdi_i clears the watchdog timeout. The edge takes effect two clock edges after the change. A level held for a single clock cycle is recognised.
- R6: When a watchdog reset pulse ends, a new full TIMEOUT_TICKS interval starts. A stuck wdi_i gives repeated pulses.
- R7: While wdi_float_i is high (after synchronization), the watchdog timer is held at zero and causes no reset. After wdi_float_i falls, a full TIMEOUT_TICKS interval is needed to expire. The interval counts ticks from the third clock edge after the fall.
- R8: The watchdog timer is held cleared while reset is asserted for any cause, including a supply hold longer than the timeout. It counts its first tick at the first edge after release.
- R9: With RST_ACTIVE_LOW=1, rst_o is low when asserted. With RST_ACTIVE_LOW=0, rst_o is high when asserted. Two instances that differ only in this parameter give exact complements on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| supply_ok_i | input | 1 | Synchronous supply-good flag, high when the supply is above threshold |
| tick_i | input | 1 | Timebase tick, one-cycle pulse |
| wdi_i | input | 1 | Watchdog service input, asynchronous |
| wdi_float_i | input | 1 | High when wdi_i is detected floating, asynchronous |
| rst_o | output | 1 | Processor reset, polarity set by RST_ACTIVE_LOW |

## Verification
The assertions assume three things about the inputs:
- supply_ok_i is already synchronous to clk_i;
- tick_i is a pulse that fits the counters without skipping states;
- the watchdog inputs hold each level for at least one clock cycle.

The stimulus meets these assumptions as follows:
- It changes every input on the falling clock edge.
- It emits ticks with random gaps of one to three idle cycles.
- It services the watchdog at random intervals of at most TIMEOUT_TICKS-2 ticks. This margin covers the two-edge synchronizer delay, so a correctly serviced run can never time out.
- Supply drops are held for random lengths of at least several cycles, and one drop lasts longer than a watchdog timeout.

// File: rtl/sup_pkg.sv
package sup_pkg;
  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_PULSE = 2'd1,
    ST_IDLE  = 2'd2
  } rst_state_e;

  function automatic int unsigned cnt_width(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val);
  endfunction
endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q[0] <= '0;
    else         stage_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '0;
      else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sup_wdog.sv
module sup_wdog #(
  parameter int unsigned TIMEOUT_TICKS = 1600
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic wdi_s_i,
  input  logic float_s_i,
  input  logic hold_i,
  output logic expire_o
);
  import sup_pkg::*;
  localparam int unsigned CW = cnt_width(TIMEOUT_TICKS);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_TICKS - 1);

  logic          wdi_q;
  logic          wdi_edge;
  logic          clr;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wdi_q <= 1'b0;
    else         wdi_q <= wdi_s_i;
  end

  assign wdi_edge = wdi_s_i ^ wdi_q;
  assign clr      = hold_i | float_s_i | wdi_edge;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clr)             cnt_q <= '0;
    else if (tick_i) begin
      if (cnt_q == LAST)      cnt_q <= '0;
      else                    cnt_q <= cnt_q + 1'b1;
    end
  end

  assign expire_o = tick_i & ~clr & (cnt_q == LAST);

  p_cnt_range_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  p_hold_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> (cnt_q == '0));
  p_float_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    float_s_i |=> (cnt_q == '0));
  p_edge_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdi_s_i != wdi_q) |=> (cnt_q == '0));
endmodule

// File: rtl/sup_pulse.sv
module sup_pulse #(
  parameter int unsigned PULSE_TICKS = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic supply_ok_i,
  input  logic trig_i,
  output logic active_o
);
  import sup_pkg::*;
  localparam int unsigned CW = cnt_width(PULSE_TICKS);
  localparam logic [CW-1:0] LAST = CW'(PULSE_TICKS - 1);

  rst_state_e    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_HOLD: begin
        cnt_d = '0;
        if (supply_ok_i) state_d = ST_PULSE;
      end
      ST_PULSE: begin
        if (!supply_ok_i) begin
          state_d = ST_HOLD;
          cnt_d   = '0;
        end else if (tick_i) begin
          if (cnt_q == LAST) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
      end
      ST_IDLE: begin
        cnt_d = '0;
        if (!supply_ok_i) state_d = ST_HOLD;
        else if (trig_i)  state_d = ST_PULSE;
      end
      default: begin
        state_d = ST_HOLD;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HOLD;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign active_o = (state_q != ST_IDLE);

  p_low_holds_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !supply_ok_i |=> active_o);
  p_trig_asserts_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_i |=> active_o);
  p_release_on_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active_o) |-> $past(tick_i && supply_ok_i));
  p_cnt_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
endmodule

// File: rtl/sup_core.sv
module sup_core #(
  parameter int unsigned TIMEOUT_TICKS  = 1600,
  parameter int unsigned PULSE_TICKS    = 200,
  parameter int unsigned SYNC_STAGES    = 2,
  parameter bit          RST_ACTIVE_LOW = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic supply_ok_i,
  input  logic tick_i,
  input  logic wdi_i,
  input  logic wdi_float_i,
  output logic rst_o
);
  logic [1:0] wd_raw, wd_sync;
  logic       wd_expire;
  logic       rst_active;

  assign wd_raw = {wdi_float_i, wdi_i};

  sup_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (wd_raw),
    .q_o    (wd_sync)
  );

  sup_wdog #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) i_wdog (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .wdi_s_i   (wd_sync[0]),
    .float_s_i (wd_sync[1]),
    .hold_i    (rst_active),
    .expire_o  (wd_expire)
  );

  sup_pulse #(.PULSE_TICKS(PULSE_TICKS)) i_pulse (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_i),
    .supply_ok_i (supply_ok_i),
    .trig_i      (wd_expire),
    .active_o    (rst_active)
  );

  if (RST_ACTIVE_LOW) begin : g_low
    assign rst_o = ~rst_active;
  end else begin : g_high
    assign rst_o = rst_active;
  end

  p_expire_needs_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wd_expire |-> !rst_active);
endmodule

// File: tb/test_sup_core.sv
module test_sup_core;
  localparam int unsigned TO_T = 8;
  localparam int unsigned PW_T = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic supply_ok = 1'b0;
  logic tick = 1'b0;
  logic wdi = 1'b0;
  logic wdi_float = 1'b0;
  logic rst_n_o, rst_h_o;

  int n_chk = 0;
  int n_fail = 0;
  int mism = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  sup_core #(.TIMEOUT_TICKS(TO_T), .PULSE_TICKS(PW_T), .RST_ACTIVE_LOW(1'b1)) i_sup_core (
    .clk_i(clk), .rst_ni(rst_ni), .supply_ok_i(supply_ok), .tick_i(tick),
    .wdi_i(wdi), .wdi_float_i(wdi_float), .rst_o(rst_n_o)
  );

  sup_core #(.TIMEOUT_TICKS(TO_T), .PULSE_TICKS(PW_T), .RST_ACTIVE_LOW(1'b0)) i_sup_core_hi (
    .clk_i(clk), .rst_ni(rst_ni), .supply_ok_i(supply_ok), .tick_i(tick),
    .wdi_i(wdi), .wdi_float_i(wdi_float), .rst_o(rst_h_o)
  );

  function automatic bit asserted();
    return (rst_n_o == 1'b0);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // R9 complement monitor
  always @(negedge clk) if (rst_n_o !== ~rst_h_o) mism++;

  // tick generator: one-cycle pulses, random gaps
  initial begin
    forever begin
      repeat ($urandom_range(1, 3)) @(negedge clk);
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  end

  // count ticks until the reset output changes level
  task automatic meas(input int skip, output int n);
    bit start;
    start = asserted();
    repeat (skip) @(posedge clk);
    n = 0;
    forever begin
      @(posedge clk);
      if (tick) n++;
      @(negedge clk);
      if (asserted() != start || n > 1000) break;
    end
  endtask

  // wait k ticks, counting negedges with reset asserted
  task automatic wait_ticks(input int k, inout int bad);
    int seen;
    seen = 0;
    while (seen < k) begin
      @(posedge clk);
      if (tick) seen++;
      @(negedge clk);
      if (asserted()) bad++;
    end
  endtask

  initial begin
    int n, bad, hold;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    chk(asserted(), "R1 reset asserted during rst_ni", rst_n_o, 0);
    chk(rst_h_o == 1'b1, "R9 active-high form during rst_ni", rst_h_o, 1);
    rst_ni = 1'b1;
    bad = 0;
    repeat (20) begin @(negedge clk); if (!asserted()) bad++; end
    chk(bad == 0, "R1 held while supply low after reset", bad, 0);

    supply_ok = 1'b1;
    meas(1, n);
    chk(n == PW_T, "R3 power-up pulse ticks", n, PW_T);

    meas(0, n);
    chk(n == TO_T, "R4 stuck wdi timeout ticks", n, TO_T);
    meas(0, n);
    chk(n == PW_T, "R4 watchdog pulse ticks", n, PW_T);
    meas(0, n);
    chk(n == TO_T, "R6 fresh timeout after watchdog pulse", n, TO_T);
    meas(0, n);
    chk(n == PW_T, "R6 second watchdog pulse", n, PW_T);

    // R5 random service, mixing toggles and one-cycle pulses
    bad = 0;
    for (int i = 0; i < 40; i++) begin
      wait_ticks($urandom_range(1, TO_T - 2), bad);
      if (i % 3 == 0) begin
        wdi = ~wdi;
        @(negedge clk);
        if (asserted()) bad++;
        wdi = ~wdi;
      end else begin
        wdi = ~wdi;
      end
    end
    chk(bad == 0, "R5 serviced watchdog never resets", bad, 0);

    // R7 float disables
    wdi_float = 1'b1;
    bad = 0;
    wait_ticks(3 * TO_T, bad);
    chk(bad == 0, "R7 no reset while floating", bad, 0);
    @(negedge clk);
    wdi_float = 1'b0;
    meas(2, n);
    chk(n == TO_T, "R7 full timeout after float ends", n, TO_T);

    // R3 brown-out during pulse restarts the width
    wait_ticks(2, bad);
    supply_ok = 1'b0;
    bad = 0;
    hold = $urandom_range(5, 30);
    repeat (hold) begin @(negedge clk); if (!asserted()) bad++; end
    chk(bad == 0, "R2 held during mid-pulse brown-out", bad, 0);
    supply_ok = 1'b1;
    meas(1, n);
    chk(n == PW_T, "R3 pulse restarted after mid-pulse drop", n, PW_T);

    // R2 brown-out from idle, random lengths; one longer than timeout (R8)
    for (int j = 0; j < 4; j++) begin
      wdi = ~wdi;
      wait_ticks($urandom_range(1, TO_T - 3), bad);
      supply_ok = 1'b0;
      @(negedge clk);
      chk(asserted(), "R2 assert one edge after supply drop", rst_n_o, 0);
      bad = 0;
      if (j == 3) begin
        n = 0;
        while (n < 3 * TO_T) begin
          @(posedge clk);
          if (tick) n++;
          @(negedge clk);
          if (!asserted()) bad++;
        end
      end else begin
        hold = $urandom_range(5, 50);
        repeat (hold) begin @(negedge clk); if (!asserted()) bad++; end
      end
      chk(bad == 0, "R2 held while supply low", bad, 0);
      supply_ok = 1'b1;
      meas(1, n);
      chk(n == PW_T, "R3 pulse after brown-out", n, PW_T);
    end
    meas(0, n);
    chk(n == TO_T, "R8 timer cleared by reset, full timeout after release", n, TO_T);

    chk(mism == 0, "R9 polarity forms are complements", mism, 0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule